// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block produces the two lowest address bits for a four-beat memory burst. When a burst opens, the caller presents the starting value of those two bits together with a load strobe. On later clock edges, an active-low advance strobe moves the sequencer one beat forward. When the advance strobe is high, the sequencer holds its current beat.

A static order input picks one of two beat orders. In the linear order, each beat is the previous beat plus one, modulo four. In the exclusive-or order, beat k is the starting value XOR k. In both orders, the step after the fourth beat returns the output to the starting value.

Inside, a four-state beat machine counts beats separately from the stored starting value, and a small combinational former builds the output from the two.

The beat machine has four states: `BEAT_0`, `BEAT_1`, `BEAT_2` and `BEAT_3`. Its transitions are:
- **load** (any state to `BEAT_0`), taken whenever the load strobe is high.
- **step** (`BEAT_0` to `BEAT_1`, `BEAT_1` to `BEAT_2`, `BEAT_2` to `BEAT_3`), taken when the advance strobe is low and there is no load.
- **wrap** (`BEAT_3` to `BEAT_0`), taken under the same condition as step.
- **hold** (each state to itself), taken when the advance strobe is high and there is no load.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is asserted and after its release, before any load, `addr_o` is 2'b00.
- R2: On an edge with `load_i` high, the start value is captured. From that edge on, `addr_o` equals the captured `start_i`, whatever the order input is.
- R3: The advance strobe has no effect on an edge that loads. A load with `adv_n_i` low still gives `addr_o` equal to `start_i`, not the next beat.
- R4: On an edge with `load_i` low and `adv_n_i` high, `addr_o` keeps its value.
- R5: With `mode_i` = 0 (linear order), an edge with `load_i` low and `adv_n_i` low sets `addr_o` to its previous value plus one, modulo 4.
- R6: With `mode_i` = 1 (exclusive-or order), after k advancing edges since the last load (k from 0 to 3), `addr_o` equals the start value XOR k.
- R7: The fourth advancing edge after a load returns `addr_o` to the start value in both orders, and the sequence then repeats.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Opens a burst by capturing `start_i` |
| start_i | input | 2 | Starting value of the two low address bits |
| adv_n_i | input | 1 | Active-low advance strobe |
| mode_i | input | 1 | Beat order: 0 linear, 1 exclusive-or |
| addr_o | output | 2 | Current burst address bits |

## Verification
The assertions assume the order input stays fixed across an advancing edge. The linear-step and hold properties excuse any edge on which `mode_i` changes, rather than assuming it never does. They also assume the strobes carry known values from the first clock after reset. The stimulus changes `mode_i` only on a falling clock edge, and only just before a load opens a new burst, so no burst mixes the two orders.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
    localparam int BEAT_W    = 2;
    localparam int NUM_BEATS = 1 << BEAT_W;

    typedef enum logic [BEAT_W-1:0] {
        BEAT_0 = 2'd0,
        BEAT_1 = 2'd1,
        BEAT_2 = 2'd2,
        BEAT_3 = 2'd3
    } beat_e;

    typedef enum logic {
        ORDER_LINEAR = 1'b0,
        ORDER_XOR    = 1'b1
    } order_e;
endpackage

// File: rtl/burst_beat_fsm.sv
module burst_beat_fsm
    import burst_seq_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load_i,
    input  logic  adv_n_i,
    output beat_e beat_o
);
    beat_e state_q;
    beat_e state_d;

    // Next-state logic: a load wins over an advance on the same edge.
    always_comb begin
        state_d = state_q;
        if (load_i) begin
            state_d = BEAT_0;
        end else if (!adv_n_i) begin
            unique case (state_q)
                BEAT_0: state_d = BEAT_1;
                BEAT_1: state_d = BEAT_2;
                BEAT_2: state_d = BEAT_3;
                BEAT_3: state_d = BEAT_0;
                default: state_d = BEAT_0;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BEAT_0;
        else        state_q <= state_d;
    end

    // Output process
    always_comb begin
        beat_o = state_q;
    end

    // R7
    beat_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BEAT_3 && !load_i && !adv_n_i) |=> (state_q == BEAT_0));

    // R4
    beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && adv_n_i) |=> $stable(state_q));
endmodule

// File: rtl/burst_addr_former.sv
module burst_addr_former
    import burst_seq_pkg::*;
(
    input  logic [BEAT_W-1:0] start_i,
    input  beat_e             beat_i,
    input  order_e            order_i,
    output logic [BEAT_W-1:0] addr_o
);
    logic [BEAT_W-1:0] lin_addr;
    logic [BEAT_W-1:0] xor_addr;

    always_comb begin
        lin_addr = start_i + BEAT_W'(beat_i);
        xor_addr = start_i ^ BEAT_W'(beat_i);
        unique case (order_i)
            ORDER_LINEAR: addr_o = lin_addr;
            ORDER_XOR:    addr_o = xor_addr;
            default:      addr_o = lin_addr;
        endcase
    end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [BEAT_W-1:0] start_i,
    input  logic              adv_n_i,
    input  logic              mode_i,
    output logic [BEAT_W-1:0] addr_o
);
    logic [BEAT_W-1:0] start_q;
    beat_e             beat;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      start_q <= '0;
        else if (load_i) start_q <= start_i;
    end

    burst_beat_fsm beat_fsm_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_i),
        .adv_n_i (adv_n_i),
        .beat_o  (beat)
    );

    burst_addr_former former_i (
        .start_i (start_q),
        .beat_i  (beat),
        .order_i (order_e'(mode_i)),
        .addr_o  (addr_o)
    );

    // R2
    load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && adv_n_i) |=> (addr_o == $past(start_i)));

    // R3
    load_beats_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !adv_n_i) |=> (addr_o == $past(start_i)));

    // R4
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && adv_n_i) |=> ($stable(addr_o) || !$stable(mode_i)));

    // R5
    linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !adv_n_i && !mode_i) |=>
            (mode_i || addr_o == BEAT_W'($past(addr_o) + 1'b1)));
endmodule

// File: tb/burst_addr_seq_tb_top.sv
module burst_addr_seq_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load_i = 1'b0;
    logic [1:0] start_i = 2'd0;
    logic       adv_n_i = 1'b1;
    logic       mode_i = 1'b0;
    logic [1:0] addr_o;

    int checks = 0;
    int errors = 0;
    int ref_start = 0;
    int ref_k = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_addr_seq dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_i),
        .start_i (start_i),
        .adv_n_i (adv_n_i),
        .mode_i  (mode_i),
        .addr_o  (addr_o)
    );

    function automatic logic [1:0] ref_addr();
        if (mode_i) return 2'(ref_start ^ ref_k);
        else        return 2'((ref_start + ref_k) % 4);
    endfunction

    task automatic chk(string tag, logic [1:0] act, logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: addr_o=%0d expected %0d", tag, act, exp);
        end
    endtask

    // Drives one edge's inputs, updates the model at the edge, checks at the falling edge.
    task automatic step(string tag, logic ld, logic [1:0] st, logic adv_n);
        load_i  = ld;
        start_i = st;
        adv_n_i = adv_n;
        @(posedge clk);
        if (ld) begin
            ref_start = st;
            ref_k     = 0;
        end else if (!adv_n) begin
            ref_k = (ref_k + 1) % 4;
        end
        @(negedge clk);
        chk(tag, addr_o, ref_addr());
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        errors++;
        $display("FAIL watchdog: run did not finish, addr_o=%0d expected end of test", addr_o);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        chk("R1 in reset", addr_o, 2'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", addr_o, 2'd0);
        step("R1 idle hold", 1'b0, 2'd3, 1'b1);

        // Linear order
        mode_i = 1'b0;
        step("R2 linear load", 1'b1, 2'd2, 1'b1);
        step("R5 linear beat1", 1'b0, 2'd0, 1'b0);
        step("R5 linear beat2", 1'b0, 2'd1, 1'b0);
        step("R5 linear beat3", 1'b0, 2'd0, 1'b0);
        step("R7 linear wrap", 1'b0, 2'd0, 1'b0);
        step("R4 linear hold", 1'b0, 2'd1, 1'b1);
        step("R4 linear hold2", 1'b0, 2'd3, 1'b1);
        step("R5 linear after hold", 1'b0, 2'd0, 1'b0);
        step("R3 linear load with adv", 1'b1, 2'd1, 1'b0);
        step("R5 linear from 1", 1'b0, 2'd0, 1'b0);
        step("R2 reload mid burst", 1'b1, 2'd3, 1'b1);
        for (int i = 0; i < 8; i++) step("R7 linear repeat", 1'b0, 2'd0, 1'b0);

        // Exclusive-or order
        mode_i = 1'b1;
        step("R2 xor load", 1'b1, 2'd2, 1'b1);
        step("R6 xor beat1", 1'b0, 2'd0, 1'b0);
        step("R6 xor beat2", 1'b0, 2'd0, 1'b0);
        step("R4 xor hold", 1'b0, 2'd0, 1'b1);
        step("R6 xor beat3", 1'b0, 2'd0, 1'b0);
        step("R7 xor wrap", 1'b0, 2'd0, 1'b0);
        step("R3 xor load with adv", 1'b1, 2'd3, 1'b0);
        for (int i = 0; i < 4; i++) step("R6 xor from 3", 1'b0, 2'd0, 1'b0);
        step("R2 xor load 1", 1'b1, 2'd1, 1'b1);
        for (int i = 0; i < 6; i++) step("R6 xor from 1", 1'b0, 2'd2, 1'b0);
        step("R2 xor load 0", 1'b1, 2'd0, 1'b1);
        for (int i = 0; i < 4; i++) step("R7 xor from 0", 1'b0, 2'd0, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule